// File: doc/BRIEF.md
# Time-Stamped Pixel Matrix Sweeper

This block reads out a data-push pixel matrix in which every pixel keeps its own hit flag and a copy of the bunch-crossing count taken when the hit arrived. Comparator outputs reach the block as one-cycle digital pulses, one bit per pixel. A free-running bunch counter advances once every `BC_DIV` clocks. Each pulse sets the pixel's hit flag and stores that count in the pixel's timestamp latch.

A single sweep pointer walks the columns. The columns are split evenly into `NUM_SUBS` submatrices, so the walk serves submatrix 0, 1, 2 and 3 in turn and then wraps. An empty column costs one cycle. In a column that holds hits, the hit pixels are read lowest row first and packed into 20-bit words. The words leave on a valid/ready stream. A pixel's flag is cleared on the clock edge where its word is taken. Pixels without a hit are never masked during a sweep. A pulse on a pixel whose flag is still set is discarded and counted.

Top module: `pixelSweeper`

## Requirements
- R1: After reset, `wordValid` is low, `lostHits` is zero, the sweep pointer is on column 0 of submatrix 0, and the bunch counter is zero.
- R2: A pixel stores the bunch count in force at the clock edge that samples its pulse. The count starts at 0 after reset and increments every `BC_DIV` clocks (default 40). Bits [3:0] of the word carry the low four bits of the stored count.
- R3: Word layout is [19:18] submatrix index, [17:12] column inside the submatrix, [11:4] row, and [3:0] timestamp. Submatrix s holds global columns s*CPS to s*CPS+CPS-1, where CPS = `NUM_COLS`/`NUM_SUBS`. Pulse bit column*`NUM_ROWS`+row belongs to that pixel.
- R4: The pointer visits global columns in ascending order and wraps from the last column to column 0. With nothing latched, it moves one column per clock. A hit latched in column k just after reset is therefore first presented after clock edge k+1.
- R5: Inside a column, the lowest-row pending hit is presented first. While `wordReady` stays high, one word is accepted per clock.
- R6: While `wordValid` is high and `wordReady` is low, `wordData` stays unchanged and the pointer does not move. Pixels keep latching new pulses during the stall.
- R7: A pixel's flag is cleared at the edge where its word is accepted. A pulse sampled at the following edge is latched as a new hit and is read out later.
- R8: A pulse on a pixel whose flag is set is dropped and adds one to `lostHits`. This includes the edge where that pixel's word is accepted. The stored timestamp is kept unchanged.
- R9: Every latched hit produces exactly one word, and no word appears without a latched hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sweep clock |
| rstN | input | 1 | Synchronous active-low reset |
| hitPulse | input | NUM_COLS*NUM_ROWS | One-cycle hit pulses, bit column*NUM_ROWS+row |
| wordReady | input | 1 | Downstream accepts the current word |
| wordValid | output | 1 | `wordData` holds a pixel word |
| wordData | output | 20 | Submatrix, column, row and timestamp of one hit |
| lostHits | output | LOST_W | Count of pulses dropped on already-set pixels |

## Verification
The bench targets the following corner cases:

- **Lower-row hit during a stall.** A hit lands on a lower row of the column being held while ready is low. A design that re-picks combinationally would change the held word.
- **Pulse on the acceptance edge.** A pulse arrives on the very edge where its pixel's word is accepted. A design that gives the new pulse priority over the clear would lose the count, or report the hit twice.
- **Pulse one edge after acceptance.** The next pulse arrives one edge after acceptance. A design that keeps the pixel blocked would never report it.
- **Second hit on a set pixel.** A second hit is aimed at an already-set pixel, with a different bunch count. A design that overwrites the timestamp would send the wrong low bits.
- **Skip timing and read order.** Hits are spread across columns of several submatrices. Exact presentation cycles check the one-clock skip, and back-to-back reads check the lowest-row ordering.

// File: rtl/sweepPkg.sv
package sweepPkg;
  localparam int SUB_FW  = 2;
  localparam int CIS_FW  = 6;
  localparam int ROW_FW  = 8;
  localparam int TSO_FW  = 4;
  localparam int GCOL_FW = SUB_FW + CIS_FW;
  localparam int WORD_W  = SUB_FW + CIS_FW + ROW_FW + TSO_FW;

  // strobes from the sweep control to the pixel array
  typedef struct packed {
    logic [GCOL_FW-1:0] selCol;   // column driving the shared bus
    logic [ROW_FW-1:0]  pickRow;  // row whose timestamp goes on the bus
    logic               clrEn;    // held word accepted this cycle
    logic [ROW_FW-1:0]  clrRow;   // row of the held word in selCol
  } sweepStrb_t;
endpackage

// File: rtl/pixelMatrix.sv
module pixelMatrix
  import sweepPkg::*;
#(
  parameter int NUM_COLS = 16,
  parameter int NUM_ROWS = 12,
  parameter int TS_W     = 4,
  parameter int BC_DIV   = 40,
  parameter int LOST_W   = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_COLS*NUM_ROWS-1:0] hitPulse,
  input  sweepStrb_t                   strb,
  output logic [NUM_ROWS-1:0]          colHits,
  output logic [TS_W-1:0]              busTs,
  output logic [LOST_W-1:0]            lostHits
);
  localparam int NUM_PIX = NUM_COLS * NUM_ROWS;
  localparam int DIV_W   = (BC_DIV > 1) ? $clog2(BC_DIV) : 1;

  logic [DIV_W-1:0]    divCnt;
  logic [TS_W-1:0]     bcNow;
  logic [NUM_ROWS-1:0] colView [NUM_COLS];
  logic [TS_W-1:0]     tsCol   [NUM_COLS][NUM_ROWS];
  logic [NUM_PIX-1:0]  lostVec;

  // bunch-crossing counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
      bcNow  <= '0;
    end else if (divCnt == DIV_W'(BC_DIV - 1)) begin
      divCnt <= '0;
      bcNow  <= bcNow + 1'b1;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  // one hit latch and one timestamp latch per pixel
  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
      logic hitQ;
      logic [TS_W-1:0] tsQ;
      logic pulse, clrMe;
      assign pulse = hitPulse[c*NUM_ROWS + r];
      assign clrMe = strb.clrEn && (strb.selCol == GCOL_FW'(c))
                     && (strb.clrRow == ROW_FW'(r));
      always_ff @(posedge clk) begin
        if (!rstN) begin
          hitQ <= 1'b0;
          tsQ  <= '0;
        end else begin
          if (clrMe)      hitQ <= 1'b0;
          else if (pulse) hitQ <= 1'b1;
          if (pulse && !hitQ) tsQ <= bcNow;
        end
      end
      assign lostVec[c*NUM_ROWS + r] = pulse && hitQ;
      assign colView[c][r]           = hitQ;
      assign tsCol[c][r]             = tsQ;
    end
  end

  // shared column bus
  always_comb begin
    colHits = '0;
    busTs   = '0;
    for (int c = 0; c < NUM_COLS; c++) begin
      if (strb.selCol == GCOL_FW'(c)) begin
        colHits = colView[c];
        for (int r = 0; r < NUM_ROWS; r++)
          if (strb.pickRow == ROW_FW'(r)) busTs = tsCol[c][r];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) lostHits <= '0;
    else       lostHits <= lostHits + LOST_W'($countones(lostVec));
  end
endmodule

// File: rtl/sweepCtrl.sv
module sweepCtrl
  import sweepPkg::*;
#(
  parameter int NUM_COLS = 16,
  parameter int NUM_ROWS = 12,
  parameter int NUM_SUBS = 4,
  parameter int TS_W     = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_ROWS-1:0] colHits,
  input  logic [TS_W-1:0]     busTs,
  input  logic                wordReady,
  output sweepStrb_t          strb,
  output logic                wordValid,
  output logic [WORD_W-1:0]   wordData
);
  localparam int CPS   = NUM_COLS / NUM_SUBS;
  localparam int SUB_W = (NUM_SUBS > 1) ? $clog2(NUM_SUBS) : 1;
  localparam int CIS_W = (CPS > 1) ? $clog2(CPS) : 1;

  logic [SUB_W-1:0]    subIdx;
  logic [CIS_W-1:0]    colInSub;
  logic [ROW_FW-1:0]   heldRow, pickRow;
  logic [NUM_ROWS-1:0] avail;
  logic                found, canLoad;

  // pending hits other than the one already held, lowest row wins
  always_comb begin
    for (int r = 0; r < NUM_ROWS; r++)
      avail[r] = colHits[r] && !(wordValid && heldRow == ROW_FW'(r));
    found   = 1'b0;
    pickRow = '0;
    for (int r = NUM_ROWS - 1; r >= 0; r--) begin
      if (avail[r]) begin
        found   = 1'b1;
        pickRow = ROW_FW'(r);
      end
    end
  end

  assign canLoad      = !wordValid || wordReady;
  assign strb.selCol  = GCOL_FW'(subIdx) * GCOL_FW'(CPS) + GCOL_FW'(colInSub);
  assign strb.pickRow = pickRow;
  assign strb.clrEn   = wordValid && wordReady;
  assign strb.clrRow  = heldRow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      subIdx    <= '0;
      colInSub  <= '0;
      wordValid <= 1'b0;
      wordData  <= '0;
      heldRow   <= '0;
    end else if (canLoad) begin
      if (found) begin
        wordValid <= 1'b1;
        heldRow   <= pickRow;
        wordData  <= {SUB_FW'(subIdx), CIS_FW'(colInSub), pickRow, TSO_FW'(busTs)};
      end else begin
        wordValid <= 1'b0;
        if (colInSub == CIS_W'(CPS - 1)) begin
          colInSub <= '0;
          subIdx   <= (subIdx == SUB_W'(NUM_SUBS - 1)) ? '0 : subIdx + 1'b1;
        end else begin
          colInSub <= colInSub + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pixelSweeper.sv
module pixelSweeper
  import sweepPkg::*;
#(
  parameter int NUM_COLS = 16,
  parameter int NUM_ROWS = 12,
  parameter int NUM_SUBS = 4,
  parameter int TS_W     = 4,
  parameter int BC_DIV   = 40,
  parameter int LOST_W   = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_COLS*NUM_ROWS-1:0] hitPulse,
  input  logic                         wordReady,
  output logic                         wordValid,
  output logic [WORD_W-1:0]            wordData,
  output logic [LOST_W-1:0]            lostHits
);
  sweepStrb_t          strb;
  logic [NUM_ROWS-1:0] colHits;
  logic [TS_W-1:0]     busTs;

  pixelMatrix #(
    .NUM_COLS(NUM_COLS), .NUM_ROWS(NUM_ROWS), .TS_W(TS_W),
    .BC_DIV(BC_DIV), .LOST_W(LOST_W)
  ) i_pixelMatrix (
    .clk(clk), .rstN(rstN), .hitPulse(hitPulse), .strb(strb),
    .colHits(colHits), .busTs(busTs), .lostHits(lostHits)
  );

  sweepCtrl #(
    .NUM_COLS(NUM_COLS), .NUM_ROWS(NUM_ROWS), .NUM_SUBS(NUM_SUBS), .TS_W(TS_W)
  ) i_sweepCtrl (
    .clk(clk), .rstN(rstN), .colHits(colHits), .busTs(busTs),
    .wordReady(wordReady), .strb(strb), .wordValid(wordValid), .wordData(wordData)
  );
endmodule

// File: rtl/sweepChecker.sv
module sweepChecker
  import sweepPkg::*;
#(
  parameter int NUM_PIX  = 192,
  parameter int NUM_ROWS = 12,
  parameter int CPS      = 4,
  parameter int LOST_W   = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_PIX-1:0] hitPulse,
  input logic               wordReady,
  input logic               wordValid,
  input logic [WORD_W-1:0]  wordData,
  input logic [LOST_W-1:0]  lostHits
);
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $rose(rstN) |-> (!wordValid && lostHits == '0));

  // R3
  field_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> (int'(wordData[TSO_FW +: ROW_FW]) < NUM_ROWS)
               && (int'(wordData[TSO_FW + ROW_FW +: CIS_FW]) < CPS));

  // R6
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && !wordReady) |=> (wordValid && $stable(wordData)));

  // R7
  no_reread_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && wordReady) |=>
      !(wordValid && wordData[WORD_W-1:TSO_FW] == $past(wordData[WORD_W-1:TSO_FW])));

  // R8
  lost_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(lostHits) |-> $past(|hitPulse));
endmodule

bind pixelSweeper sweepChecker #(
  .NUM_PIX(NUM_COLS*NUM_ROWS), .NUM_ROWS(NUM_ROWS),
  .CPS(NUM_COLS/NUM_SUBS), .LOST_W(LOST_W)
) i_sweepChecker (
  .clk(clk), .rstN(rstN), .hitPulse(hitPulse), .wordReady(wordReady),
  .wordValid(wordValid), .wordData(wordData), .lostHits(lostHits)
);

// File: tb/test_pixelSweeper.sv
module test_pixelSweeper;
  import sweepPkg::*;

  localparam int NC  = 16;
  localparam int NR  = 12;
  localparam int NS  = 4;
  localparam int CPS = NC / NS;
  localparam int BCD = 40;

  // {column, row, gap}: gap 0 means the next entry fires in the same cycle
  localparam logic [15:0] STIM [16] = '{
    {4'd0,  4'd0,  8'd3},  {4'd5,  4'd11, 8'd0}, {4'd5,  4'd3, 8'd2},
    {4'd15, 4'd7,  8'd1},  {4'd8,  4'd8,  8'd0}, {4'd9,  4'd8, 8'd0},
    {4'd10, 4'd8,  8'd5},  {4'd1,  4'd1,  8'd50}, {4'd2, 4'd2, 8'd0},
    {4'd2,  4'd9,  8'd7},  {4'd12, 4'd0,  8'd1}, {4'd3,  4'd5, 8'd0},
    {4'd4,  4'd6,  8'd30}, {4'd13, 4'd10, 8'd2}, {4'd14, 4'd4, 8'd1},
    {4'd7,  4'd11, 8'd60}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NC*NR-1:0] hitPulse = '0;
  logic wordReady = 1'b0;
  logic wordValid;
  logic [WORD_W-1:0] wordData;
  logic [15:0] lostHits;

  int checks = 0;
  int errors = 0;
  int edgeCnt = 0;
  logic [WORD_W-1:0] gotQ[$];
  int gotEdge[$];
  logic [WORD_W-1:0] expQ[$];

  pixelSweeper #(
    .NUM_COLS(NC), .NUM_ROWS(NR), .NUM_SUBS(NS), .TS_W(4), .BC_DIV(BCD), .LOST_W(16)
  ) i_pixelSweeper (
    .clk(clk), .rstN(rstN), .hitPulse(hitPulse), .wordReady(wordReady),
    .wordValid(wordValid), .wordData(wordData), .lostHits(lostHits)
  );

  always #5 clk = ~clk;

  always @(posedge clk) edgeCnt <= rstN ? edgeCnt + 1 : 0;

  // a transfer happens at the next rising edge
  always @(negedge clk)
    if (rstN && wordValid && wordReady) begin
      gotQ.push_back(wordData);
      gotEdge.push_back(edgeCnt + 1);
    end

  function automatic logic [WORD_W-1:0] mkWord(int col, int row, int ts);
    return {SUB_FW'(col / CPS), CIS_FW'(col % CPS), ROW_FW'(row), TSO_FW'(ts % 16)};
  endfunction

  function automatic int pix(int col, int row);
    return col * NR + row;
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic tickPat();
    wordReady = ((edgeCnt % 4) != 3);
    @(posedge clk);
    #2;
  endtask

  task automatic goEdge(int m);
    while (edgeCnt < m) tick();
  endtask

  task automatic doReset();
    rstN = 1'b0;
    hitPulse = '0;
    wordReady = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    rstN = 1'b1;
    gotQ.delete();
    gotEdge.delete();
  endtask

  initial begin
    #(200000 * 10);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // ---- table walk: scoreboard of injected hits (R9, R2)
    doReset();
    for (int i = 0; i < 16; i++) begin
      int col, row, gap;
      col = int'(STIM[i][15:12]);
      row = int'(STIM[i][11:8]);
      gap = int'(STIM[i][7:0]);
      hitPulse[pix(col, row)] = 1'b1;
      expQ.push_back(mkWord(col, row, edgeCnt / BCD));
      if (gap != 0) begin
        tickPat();
        hitPulse = '0;
        for (int k = 1; k < gap; k++) tickPat();
      end
    end
    wordReady = 1'b1;
    repeat (100) tick();
    foreach (expQ[i]) begin
      int idx;
      idx = -1;
      foreach (gotQ[j]) if (idx < 0 && gotQ[j] == expQ[i]) idx = j;
      check(idx >= 0, "R9", "injected hit reported with its timestamp (R2)", 32'(idx), 32'(expQ[i]));
      if (idx >= 0) gotQ.delete(idx);
    end
    check(gotQ.size() == 0, "R9", "no extra words", 32'(gotQ.size()), 32'd0);
    check(lostHits == 16'd0, "R8", "no loss on distinct pixels", 32'(lostHits), 32'd0);

    // ---- reset state (R1)
    doReset();
    check(wordValid == 1'b0, "R1", "valid low after reset", 32'(wordValid), 32'd0);
    check(lostHits == 16'd0, "R1", "lost count cleared", 32'(lostHits), 32'd0);
    goEdge(20);
    check(wordValid == 1'b0, "R9", "no word without hits", 32'(wordValid), 32'd0);

    // ---- skip timing, stall hold, row priority (R4, R3, R6, R5)
    doReset();
    hitPulse[pix(5, 3)] = 1'b1;
    tick();
    hitPulse = '0;
    goEdge(5);
    check(wordValid == 1'b0, "R4", "column 5 not yet reached at edge 5", 32'(wordValid), 32'd0);
    goEdge(6);
    check(wordValid == 1'b1, "R4", "column 5 presented at edge 6", 32'(wordValid), 32'd1);
    check(wordData == mkWord(5, 3, 0), "R3", "word fields", 32'(wordData), 32'(mkWord(5, 3, 0)));
    goEdge(8);
    hitPulse[pix(5, 0)] = 1'b1;
    hitPulse[pix(5, 8)] = 1'b1;
    tick();
    hitPulse = '0;
    goEdge(20);
    check(wordValid && wordData == mkWord(5, 3, 0), "R6", "word held during stall",
          32'(wordData), 32'(mkWord(5, 3, 0)));
    wordReady = 1'b1;
    goEdge(26);
    wordReady = 1'b0;
    check(gotQ.size() == 3, "R5", "three words from column 5", 32'(gotQ.size()), 32'd3);
    if (gotQ.size() == 3) begin
      check(gotQ[0] == mkWord(5, 3, 0), "R5", "held row first", 32'(gotQ[0]), 32'(mkWord(5, 3, 0)));
      check(gotQ[1] == mkWord(5, 0, 0), "R5", "lowest pending row next", 32'(gotQ[1]), 32'(mkWord(5, 0, 0)));
      check(gotQ[2] == mkWord(5, 8, 0), "R5", "higher row last", 32'(gotQ[2]), 32'(mkWord(5, 8, 0)));
      check(gotEdge[2] - gotEdge[0] == 2, "R5", "one word per clock", 32'(gotEdge[2] - gotEdge[0]), 32'd2);
    end

    // ---- lost hits, timestamp kept, re-arm after read (R8, R2, R7)
    doReset();
    hitPulse[pix(2, 6)] = 1'b1;
    tick();
    hitPulse = '0;
    goEdge(45);
    hitPulse[pix(2, 6)] = 1'b1;
    tick();
    hitPulse = '0;
    check(lostHits == 16'd1, "R8", "second hit counted", 32'(lostHits), 32'd1);
    check(wordValid && wordData == mkWord(2, 6, 0), "R8", "first timestamp kept",
          32'(wordData), 32'(mkWord(2, 6, 0)));
    goEdge(50);
    wordReady = 1'b1;
    hitPulse[pix(2, 6)] = 1'b1;
    tick();
    wordReady = 1'b0;
    tick();
    hitPulse = '0;
    check(lostHits == 16'd2, "R8", "pulse on accept edge dropped", 32'(lostHits), 32'd2);
    check(gotQ.size() == 1 && gotQ[0] == mkWord(2, 6, 0), "R7", "first word accepted once",
          32'(gotQ.size()), 32'd1);
    goEdge(60);
    wordReady = 1'b1;
    goEdge(100);
    check(gotQ.size() == 2, "R7", "pixel re-armed after read", 32'(gotQ.size()), 32'd2);
    if (gotQ.size() == 2)
      check(gotQ[1] == mkWord(2, 6, 1), "R2", "new timestamp from bunch 1",
            32'(gotQ[1]), 32'(mkWord(2, 6, 1)));
    check(lostHits == 16'd2, "R7", "re-arm pulse not counted lost", 32'(lostHits), 32'd2);

    // ---- submatrix order (R4)
    doReset();
    wordReady = 1'b1;
    hitPulse[pix(14, 4)] = 1'b1;
    hitPulse[pix(3, 1)]  = 1'b1;
    hitPulse[pix(9, 0)]  = 1'b1;
    tick();
    hitPulse = '0;
    goEdge(40);
    check(gotQ.size() == 3, "R4", "three submatrix words", 32'(gotQ.size()), 32'd3);
    if (gotQ.size() == 3) begin
      check(gotQ[0] == mkWord(3, 1, 0), "R4", "submatrix 0 first", 32'(gotQ[0]), 32'(mkWord(3, 1, 0)));
      check(gotQ[1] == mkWord(9, 0, 0), "R4", "submatrix 2 next", 32'(gotQ[1]), 32'(mkWord(9, 0, 0)));
      check(gotQ[2] == mkWord(14, 4, 0), "R4", "submatrix 3 last", 32'(gotQ[2]), 32'(mkWord(14, 4, 0)));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule